// File: doc/BRIEF.md
# Audio Sample Queue with Hysteretic Service Request

This block holds up to 1024 eight-bit audio samples between a host port and a converter port. In playback the host pushes bytes and a pacing tick moves the oldest byte to the DAC output register. In record the pacing tick captures the ADC input byte into the queue and the host pops bytes from it. A service-request flag with two fill thresholds (one quarter and three quarters of capacity) tells the host when a whole 256-byte block can be moved. A wait flag tells the host that the next byte it would move cannot be taken.

The converter pace is set by an eight-bit reload constant. A divider turns the system clock into a one-microsecond strobe, and a tick is issued every `256 - constant` strobes. Loading a mode, including the idle mode that serves as the stop command, empties the queue and restarts the pacer.

Both host data paths are valid/ready streams. A byte moves on a clock edge where valid and ready are both high. `hw_ready_o` and `hr_valid_o` may fall in any cycle, because the queue fills, drains or is flushed. `hw_ready_o` does not depend on `hw_valid_i`.

Top module: `apq_sample_queue`

## Requirements
- R1: A one-cycle pulse on `mode_set_i` loads `mode_sel_i` (0 idle, 1 playback, 2 record, 3 treated as idle) and empties the queue. From the next cycle, `srq_o` and `ovf_o` are 0. Bytes offered on either host stream in that cycle are not moved.
- R2: In playback, `hw_ready_o` is high exactly when fewer than 1024 bytes are stored, and `wait_o` is high exactly when 1024 are stored. In any other mode, `hw_ready_o` is low.
- R3: In record, `hr_valid_o` is high exactly when the queue holds data, and `hr_data_o` presents the oldest stored byte, so bytes leave in arrival order. In record, `wait_o` is high when the queue is empty. In idle, `wait_o` is high.
- R4: In playback, `srq_o` is set when 256 or fewer bytes are stored and cleared when 768 or more are stored. Between those counts it keeps its value.
- R5: In record, `srq_o` is set when 768 or more bytes are stored and cleared when 256 or fewer are stored. Between those counts it keeps its value.
- R6: With constant C loaded through `tc_load_i`/`tc_i`, `sample_tick_o` pulses once every `CLK_PER_US*(256-C)` clocks, and C = 0 gives 256 microseconds. No tick occurs in idle.
- R7: In playback, each tick moves the oldest byte to `dac_data_o`. A tick on an empty queue leaves `dac_data_o` unchanged, so the last sample repeats.
- R8: In record, each tick stores `adc_data_i`. A tick on a full queue discards the new byte, keeps the stored ones, and sets `ovf_o`, which stays set until the next mode load.
- R9: A host transfer and a converter tick in the same cycle are both performed, and the stored count is unchanged by the pair.
- R10: `srq_o` is registered: it changes on the clock edge that follows the edge on which the stored count crossed a threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_set_i | input | 1 | Pulse: load mode and flush the queue |
| mode_sel_i | input | 2 | Mode to load (0 idle, 1 playback, 2 record) |
| tc_load_i | input | 1 | Pulse: load the pacing constant and restart the pacer |
| tc_i | input | 8 | Pacing constant; tick period is 256 minus this, in microseconds |
| hw_valid_i | input | 1 | Host write stream valid |
| hw_ready_o | output | 1 | Host write stream ready |
| hw_data_i | input | 8 | Host write stream byte |
| hr_valid_o | output | 1 | Host read stream valid |
| hr_ready_i | input | 1 | Host read stream ready |
| hr_data_o | output | 8 | Host read stream byte (oldest stored) |
| sample_tick_o | output | 1 | Converter pacing pulse |
| adc_data_i | input | 8 | ADC sample, captured on a record tick |
| dac_data_o | output | 8 | DAC sample register |
| srq_o | output | 1 | Service request with hysteresis |
| wait_o | output | 1 | Host must hold off |
| ovf_o | output | 1 | Sticky record overflow |

## Verification
Two functions can meet in one cycle: a host stream transfer and a converter tick act on opposite ends of the queue on the same edge. That is the playback write against the DAC pop, or the ADC capture against the host read. The bench provokes this by streaming one byte per clock while the pacer runs at its fastest setting, so every tick lands on a transfer. A cycle-accurate reference queue in the bench predicts the DAC byte, the read byte, both flags and the stream handshakes on every cycle. The bench then slows the pacer and fills the queue to full, and the number of bytes it accepts must equal the space implied by the transfers and the pops seen.

// File: rtl/apq_pkg.sv
package apq_pkg;

  typedef enum logic [1:0] {
    APQ_IDLE = 2'd0,
    APQ_PLAY = 2'd1,
    APQ_REC  = 2'd2
  } apq_mode_e;

  // Code 3 has no meaning and falls back to idle.
  function automatic apq_mode_e apq_decode(input logic [1:0] sel);
    case (sel)
      2'd1:    return APQ_PLAY;
      2'd2:    return APQ_REC;
      default: return APQ_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/apq_pacer.sv
// Microsecond strobe plus reload-style period counter.
module apq_pacer #(
  parameter int CLK_PER_US = 4,
  parameter int TCW        = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic           load_i,
  input  logic [TCW-1:0] tc_i,
  output logic           tick_o
);
  localparam int DIVW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int PW   = TCW + 1;
  localparam logic [DIVW-1:0] DIV_LAST  = DIVW'(CLK_PER_US - 1);
  localparam logic [PW-1:0]   FULL_SPAN = PW'(2 ** TCW);

  logic [TCW-1:0]  tc_q;
  logic [DIVW-1:0] div_q;
  logic [PW-1:0]   per_q;
  logic [PW-1:0]   period;
  logic            us_stb;
  logic            per_end;

  assign period  = FULL_SPAN - {1'b0, tc_q};
  assign us_stb  = (div_q == DIV_LAST);
  assign per_end = (per_q == period - PW'(1));
  assign tick_o  = run_i && !load_i && us_stb && per_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= '0;
    end else if (load_i) begin
      tc_q <= tc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      per_q <= '0;
    end else if (load_i || !run_i) begin
      div_q <= '0;
      per_q <= '0;
    end else if (us_stb) begin
      div_q <= '0;
      per_q <= per_end ? '0 : per_q + PW'(1);
    end else begin
      div_q <= div_q + DIVW'(1);
    end
  end

endmodule

// File: rtl/apq_ring.sv
// Circular byte store with occupancy count and synchronous flush.
module apq_ring #(
  parameter int DW    = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push;
  logic          do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + AW'(1);
  endfunction

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign cnt_o     = cnt_q;
  assign rd_data_o = mem[rd_ptr];
  assign do_push   = push_i && !full_o && !flush_i;
  assign do_pop    = pop_i && !empty_o && !flush_i;

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_ptr] <= push_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/apq_srq.sv
// Direction-dependent hysteresis on the fill level.
module apq_srq
  import apq_pkg::*;
#(
  parameter int CW   = 11,
  parameter int LOW  = 256,
  parameter int HIGH = 768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  apq_mode_e     mode_i,
  input  logic          flush_i,
  input  logic [CW-1:0] cnt_i,
  output logic          srq_o
);
  localparam logic [CW-1:0] LOW_MARK  = CW'(LOW);
  localparam logic [CW-1:0] HIGH_MARK = CW'(HIGH);

  logic at_low;
  logic at_high;

  assign at_low  = (cnt_i <= LOW_MARK);
  assign at_high = (cnt_i >= HIGH_MARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srq_o <= 1'b0;
    end else if (flush_i) begin
      srq_o <= 1'b0;
    end else begin
      case (mode_i)
        APQ_PLAY: begin
          if (at_low)       srq_o <= 1'b1;
          else if (at_high) srq_o <= 1'b0;
        end
        APQ_REC: begin
          if (at_high)      srq_o <= 1'b1;
          else if (at_low)  srq_o <= 1'b0;
        end
        default: srq_o <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/apq_sample_queue.sv
module apq_sample_queue
  import apq_pkg::*;
#(
  parameter int DW         = 8,
  parameter int DEPTH      = 1024,
  parameter int BLOCK      = 256,
  parameter int CLK_PER_US = 4,
  parameter int TCW        = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_set_i,
  input  logic [1:0]     mode_sel_i,
  input  logic           tc_load_i,
  input  logic [TCW-1:0] tc_i,
  input  logic           hw_valid_i,
  output logic           hw_ready_o,
  input  logic [DW-1:0]  hw_data_i,
  output logic           hr_valid_o,
  input  logic           hr_ready_i,
  output logic [DW-1:0]  hr_data_o,
  output logic           sample_tick_o,
  input  logic [DW-1:0]  adc_data_i,
  output logic [DW-1:0]  dac_data_o,
  output logic           srq_o,
  output logic           wait_o,
  output logic           ovf_o
);
  localparam int CW = $clog2(DEPTH) + 1;

  apq_mode_e     mode_q;
  logic          is_play;
  logic          is_rec;
  logic          run;
  logic          tick;
  logic [CW-1:0] q_cnt;
  logic          q_empty;
  logic          q_full;
  logic [DW-1:0] q_rd;
  logic          q_push;
  logic          q_pop;
  logic [DW-1:0] q_wdata;
  logic [DW-1:0] dac_q;
  logic          ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= APQ_IDLE;
    else if (mode_set_i) mode_q <= apq_decode(mode_sel_i);
  end

  assign is_play = (mode_q == APQ_PLAY);
  assign is_rec  = (mode_q == APQ_REC);
  assign run     = (mode_q != APQ_IDLE) && !mode_set_i;

  apq_pacer #(.CLK_PER_US(CLK_PER_US), .TCW(TCW)) u_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .load_i (tc_load_i),
    .tc_i   (tc_i),
    .tick_o (tick)
  );

  assign hw_ready_o = is_play && !q_full && !mode_set_i;
  assign hr_valid_o = is_rec && !q_empty && !mode_set_i;
  assign hr_data_o  = q_rd;

  assign q_push  = (hw_valid_i && hw_ready_o) || (is_rec && tick && !q_full);
  assign q_pop   = (hr_valid_o && hr_ready_i) || (is_play && tick && !q_empty);
  assign q_wdata = is_play ? hw_data_i : adc_data_i;

  apq_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (mode_set_i),
    .push_i      (q_push),
    .push_data_i (q_wdata),
    .pop_i       (q_pop),
    .rd_data_o   (q_rd),
    .cnt_o       (q_cnt),
    .empty_o     (q_empty),
    .full_o      (q_full)
  );

  apq_srq #(.CW(CW), .LOW(BLOCK), .HIGH(DEPTH - BLOCK)) u_srq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_q),
    .flush_i (mode_set_i),
    .cnt_i   (q_cnt),
    .srq_o   (srq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            dac_q <= '0;
    else if (is_play && tick && !q_empty) dac_q <= q_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ovf_q <= 1'b0;
    else if (mode_set_i)                 ovf_q <= 1'b0;
    else if (is_rec && tick && q_full)   ovf_q <= 1'b1;
  end

  assign dac_data_o    = dac_q;
  assign ovf_o         = ovf_q;
  assign sample_tick_o = tick;
  assign wait_o        = is_play ? q_full : (is_rec ? q_empty : 1'b1);

endmodule

// File: rtl/apq_sample_queue_chk.sv
module apq_sample_queue_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 1024,
  parameter int BLOCK = 256,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_q,
  input logic          mode_set_i,
  input logic [CW-1:0] cnt,
  input logic          srq_o,
  input logic          ovf_o,
  input logic          sample_tick_o,
  input logic [DW-1:0] dac_data_o,
  input logic          hw_ready_o,
  input logic          hr_valid_o
);
  localparam logic [CW-1:0] LOW_MARK  = CW'(BLOCK);
  localparam logic [CW-1:0] HIGH_MARK = CW'(DEPTH - BLOCK);
  localparam logic [CW-1:0] CAP       = CW'(DEPTH);

  // R1: a mode load leaves an empty queue and cleared flags
  a_r1_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set_i |=> (cnt == '0 && !srq_o && !ovf_o));

  // R2: occupancy never passes capacity
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);

  // R2: write stream never offers room when full
  a_r2_ready_room: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ready_o |-> (cnt < CAP && mode_q == 2'd1));

  // R3: read stream never offers from an empty queue
  a_r3_valid_data: assert property (@(posedge clk) disable iff (!rst_n)
    hr_valid_o |-> (cnt != '0 && mode_q == 2'd2));

  // R4: playback flag holds between the marks
  a_r4_play_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1 && !mode_set_i && cnt > LOW_MARK && cnt < HIGH_MARK)
      |=> $stable(srq_o));

  // R5: record flag holds between the marks
  a_r5_rec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2 && !mode_set_i && cnt > LOW_MARK && cnt < HIGH_MARK)
      |=> $stable(srq_o));

  // R6: pacer silent in idle
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0) |-> !sample_tick_o);

  // R7: DAC register changes only on a tick, and holds on underflow
  a_r7_dac_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick_o |=> $stable(dac_data_o));
  a_r7_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick_o && cnt == '0) |=> $stable(dac_data_o));

  // R8: overflow flag is sticky until a mode load
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !mode_set_i) |=> ovf_o);

endmodule

bind apq_sample_queue apq_sample_queue_chk #(.DW(DW), .DEPTH(DEPTH), .BLOCK(BLOCK)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_q        (mode_q),
  .mode_set_i    (mode_set_i),
  .cnt           (q_cnt),
  .srq_o         (srq_o),
  .ovf_o         (ovf_o),
  .sample_tick_o (sample_tick_o),
  .dac_data_o    (dac_data_o),
  .hw_ready_o    (hw_ready_o),
  .hr_valid_o    (hr_valid_o)
);

// File: tb/apq_sample_queue_test.sv
module apq_sample_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 16;
  localparam int DEPTH      = 1024;
  localparam int BLOCK      = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_set_i = 1'b0;
  logic [1:0] mode_sel_i = 2'd0;
  logic       tc_load_i = 1'b0;
  logic [7:0] tc_i = 8'd0;
  logic       hw_valid_i = 1'b0;
  logic       hw_ready_o;
  logic [7:0] hw_data_i = 8'd0;
  logic       hr_valid_o;
  logic       hr_ready_i = 1'b0;
  logic [7:0] hr_data_o;
  logic       sample_tick_o;
  logic [7:0] adc_data_i;
  logic [7:0] dac_data_o;
  logic       srq_o, wait_o, ovf_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  apq_sample_queue #(.DEPTH(DEPTH), .BLOCK(BLOCK), .CLK_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .mode_set_i(mode_set_i), .mode_sel_i(mode_sel_i),
    .tc_load_i(tc_load_i), .tc_i(tc_i), .hw_valid_i(hw_valid_i), .hw_ready_o(hw_ready_o),
    .hw_data_i(hw_data_i), .hr_valid_o(hr_valid_o), .hr_ready_i(hr_ready_i),
    .hr_data_o(hr_data_o), .sample_tick_o(sample_tick_o), .adc_data_i(adc_data_i),
    .dac_data_o(dac_data_o), .srq_o(srq_o), .wait_o(wait_o), .ovf_o(ovf_o)
  );

  int checks = 0;
  int errors = 0;

  // reference queue
  logic [7:0] mq [DEPTH];
  int   m_hd = 0, m_tl = 0, m_cnt = 0, m_mode = 0;
  bit   m_srq = 0, m_ovf = 0;
  logic [7:0] m_dac = 8'd0;
  logic [7:0] adc_val = 8'd0;
  bit   last_tk = 0, last_aw = 0;

  assign adc_data_i = adc_val;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycle(input bit wr, input logic [7:0] wd, input bit rd,
                       input bit ms, input logic [1:0] msel,
                       input bit ld, input logic [7:0] tcv);
    bit tk, aw, ar, exp_w;
    int old_cnt;
    hw_valid_i = wr; hw_data_i = wd; hr_ready_i = rd;
    mode_set_i = ms; mode_sel_i = msel; tc_load_i = ld; tc_i = tcv;
    #1;
    tk = sample_tick_o;
    aw = wr && hw_ready_o;
    ar = rd && hr_valid_o;
    if (ar) chk(hr_data_o == mq[m_hd], "R3", "read byte order", hr_data_o, mq[m_hd]);
    old_cnt = m_cnt;
    @(posedge clk);
    @(negedge clk);
    hw_valid_i = 0; hr_ready_i = 0; mode_set_i = 0; tc_load_i = 0;
    if (ms) begin
      m_cnt = 0; m_hd = 0; m_tl = 0; m_srq = 0; m_ovf = 0;
      m_mode = (msel == 2'd1 || msel == 2'd2) ? int'(msel) : 0;
    end else begin
      if (m_mode == 1) begin
        if (old_cnt <= BLOCK) m_srq = 1; else if (old_cnt >= DEPTH - BLOCK) m_srq = 0;
        if (aw) begin mq[m_tl] = wd; m_tl = (m_tl + 1) % DEPTH; m_cnt++; end
        if (tk && old_cnt > 0) begin m_dac = mq[m_hd]; m_hd = (m_hd + 1) % DEPTH; m_cnt--; end
      end else if (m_mode == 2) begin
        if (old_cnt >= DEPTH - BLOCK) m_srq = 1; else if (old_cnt <= BLOCK) m_srq = 0;
        if (tk) begin
          if (old_cnt < DEPTH) begin mq[m_tl] = adc_val; m_tl = (m_tl + 1) % DEPTH; m_cnt++; end
          else m_ovf = 1;
        end
        if (ar) begin m_hd = (m_hd + 1) % DEPTH; m_cnt--; end
      end else begin
        m_srq = 0;
      end
      if (tk) adc_val = adc_val + 8'd1;
    end
    last_tk = tk;
    last_aw = aw;
    #1;
    chk(srq_o == m_srq, (m_mode == 2) ? "R5" : "R4", "srq vs model", srq_o, m_srq);
    chk(ovf_o == m_ovf, "R8", "overflow flag", ovf_o, m_ovf);
    chk(dac_data_o == m_dac, "R7", "dac byte", dac_data_o, m_dac);
    exp_w = (m_mode == 1) ? (m_cnt == DEPTH) : ((m_mode == 2) ? (m_cnt == 0) : 1'b1);
    chk(wait_o == exp_w, (m_mode == 1) ? "R2" : "R3", "wait flag", wait_o, exp_w);
    chk(hw_ready_o == (m_mode == 1 && m_cnt < DEPTH), "R2", "write ready",
        hw_ready_o, (m_mode == 1 && m_cnt < DEPTH));
    chk(hr_valid_o == (m_mode == 2 && m_cnt > 0), "R3", "read valid",
        hr_valid_o, (m_mode == 2 && m_cnt > 0));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 8'd0, 0, 0, 2'd0, 0, 8'd0);
  endtask
  task automatic set_mode(input logic [1:0] m);
    cycle(0, 8'd0, 0, 1, m, 0, 8'd0);
  endtask
  task automatic load_tc(input logic [7:0] v);
    cycle(0, 8'd0, 0, 0, 2'd0, 1, v);
  endtask

  task automatic t_reset();
    int ticks = 0;
    chk(srq_o == 0, "R1", "reset srq", srq_o, 0);
    chk(wait_o == 1, "R3", "reset wait in idle", wait_o, 1);
    chk(hw_ready_o == 0, "R2", "reset ready", hw_ready_o, 0);
    chk(ovf_o == 0, "R8", "reset overflow", ovf_o, 0);
    for (int i = 0; i < 50; i++) begin idle(1); ticks += last_tk; end
    chk(ticks == 0, "R6", "no tick in idle", ticks, 0);
  endtask

  task automatic t_play();
    load_tc(8'd0);
    set_mode(2'd1);
    idle(2);
    chk(srq_o == 1, "R4", "srq set on empty playback", srq_o, 1);
    for (int i = 0; i < 767; i++) cycle(1, 8'(i), 0, 0, 2'd0, 0, 8'd0);
    idle(1);
    chk(srq_o == 1, "R4", "srq held at 767", srq_o, 1);
    cycle(1, 8'(767), 0, 0, 2'd0, 0, 8'd0);
    chk(srq_o == 1, "R10", "srq one edge late", srq_o, 1);
    idle(1);
    chk(srq_o == 0, "R10", "srq cleared after crossing", srq_o, 0);
    for (int i = 768; i < DEPTH; i++) cycle(1, 8'(i), 0, 0, 2'd0, 0, 8'd0);
    chk(hw_ready_o == 0, "R2", "ready low when full", hw_ready_o, 0);
    chk(wait_o == 1, "R2", "wait high when full", wait_o, 1);
    cycle(1, 8'hAA, 0, 0, 2'd0, 0, 8'd0);
    chk(last_aw == 0, "R2", "write refused when full", last_aw, 0);
    load_tc(8'd255);
    while (m_cnt > 257) idle(1);
    chk(srq_o == 0, "R4", "srq low above quarter", srq_o, 0);
    while (m_cnt > 256) idle(1);
    idle(1);
    chk(srq_o == 1, "R4", "srq set at quarter", srq_o, 1);
    while (m_cnt > 0) idle(1);
    idle(CPU * 3);
    chk(dac_data_o == 8'hFF, "R7", "underflow repeats last byte", dac_data_o, 8'hFF);
  endtask

  task automatic t_period(input logic [7:0] tc);
    int n = 0;
    load_tc(tc);
    do idle(1); while (!last_tk);
    do begin idle(1); n++; end while (!last_tk);
    chk(n == CPU * (256 - int'(tc)), "R6", "tick interval", n, CPU * (256 - int'(tc)));
  endtask

  task automatic t_concurrent();
    int coin = 0, acc = 0;
    load_tc(8'd255);
    set_mode(2'd1);
    for (int i = 0; i < 600; i++) begin
      cycle(1, 8'(i) ^ 8'h5A, 0, 0, 2'd0, 0, 8'd0);
      if (last_tk && last_aw) coin++;
    end
    chk(coin > 0, "R9", "write and tick coincided", coin, 1);
    load_tc(8'd0);
    for (int i = 0; i < 2000; i++) begin
      cycle(1, 8'h33, 0, 0, 2'd0, 0, 8'd0);
      if (!last_aw) break;
      acc++;
    end
    chk(acc == DEPTH - (600 - coin), "R9", "room after concurrent traffic", acc, DEPTH - (600 - coin));
    set_mode(2'd0);
  endtask

  task automatic t_record();
    logic [7:0] first;
    load_tc(8'd255);
    set_mode(2'd2);
    first = adc_val;
    chk(wait_o == 1, "R3", "wait on empty record", wait_o, 1);
    while (m_cnt < 768) idle(1);
    chk(srq_o == 0, "R10", "record srq one edge late", srq_o, 0);
    idle(1);
    chk(srq_o == 1, "R5", "record srq at three quarters", srq_o, 1);
    while (m_cnt < DEPTH) idle(1);
    idle(CPU * 3);
    chk(ovf_o == 1, "R8", "overflow on full", ovf_o, 1);
    chk(hr_data_o == first, "R8", "oldest byte kept", hr_data_o, first);
    while (m_cnt > 256) cycle(0, 8'd0, 1, 0, 2'd0, 0, 8'd0);
    idle(1);
    chk(srq_o == 0, "R5", "record srq cleared at quarter", srq_o, 0);
    chk(ovf_o == 1, "R8", "overflow sticky", ovf_o, 1);
    set_mode(2'd2);
    chk(ovf_o == 0, "R1", "mode load clears overflow", ovf_o, 0);
    chk(hr_valid_o == 0, "R1", "mode load empties", hr_valid_o, 0);
  endtask

  task automatic t_stop();
    int ticks = 0;
    set_mode(2'd1);
    for (int i = 0; i < 10; i++) cycle(1, 8'(i), 0, 0, 2'd0, 0, 8'd0);
    set_mode(2'd0);
    chk(hw_ready_o == 0, "R1", "stop closes writes", hw_ready_o, 0);
    chk(wait_o == 1, "R1", "stop raises wait", wait_o, 1);
    for (int i = 0; i < 300; i++) begin idle(1); ticks += last_tk; end
    chk(ticks == 0, "R6", "no ticks after stop", ticks, 0);
    set_mode(2'd3);
    for (int i = 0; i < 300; i++) begin idle(1); ticks += last_tk; end
    chk(ticks == 0, "R1", "code 3 acts as idle", ticks, 0);
    chk(hw_ready_o == 0, "R1", "code 3 no writes", hw_ready_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_play();
    t_period(8'd250);
    t_period(8'd0);
    t_concurrent();
    t_record();
    t_stop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule